// File: doc/BRIEF.md
# Pole Voltage Fault Detector

This block watches the legs of a three-leg voltage source converter for failed power switches. For each leg it receives a signed digitized pole voltage, the shared DC-link voltage and the top-switch gate command. From the gate command it forms the pole voltage an ideal leg would produce: half the link voltage, positive when the top switch is commanded on and negative when it is off. It subtracts this value from the measurement, takes the magnitude of the difference and compares that magnitude against a programmable voltage threshold.

Switching edges and dead time produce short error spikes even on a healthy leg. To reject them, a second criterion measures how long each over-threshold pulse lasts. It counts on a slow tick enable and restarts from zero whenever the pulse ends. A leg is declared faulty only when one continuous pulse lasts for the programmed number of ticks. Once declared, the flag stays set, that leg's detection stops, and only a synchronous reset clears it. The legs are handled by identical, independent channels.

Top module: `pole_fault_detector`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every bit of `fault` is 0.
- R2: The expected pole voltage of a leg is `vdc >>> 1` (arithmetic shift, so 801 gives 400) when its gate bit is 1, and the negation of that when the bit is 0. A leg whose measurement equals this value never raises its flag, however many ticks pass.
- R3: A leg's error counts as present only when the magnitude of (measured minus expected) is strictly greater than `thr_volt`. A magnitude equal to `thr_volt` never leads to a fault. The rule applies to both signs of the error.
- R4: The pulse duration advances only on clock edges where `tick` is 1. An error held for any number of cycles without a tick raises no flag.
- R5: With the error present continuously, the flag rises at the clock edge of the `thr_time`-th tick counted from the start of the pulse, and not before.
- R6: When the error disappears for at least one clock edge, the pulse count restarts from zero. Pulses of `thr_time`-1 ticks separated by such gaps never raise the flag.
- R7: Each leg is judged only on its own measurement and gate bit. A fault on one leg leaves the other flags at 0.
- R8: A raised flag stays at 1 until reset, whatever the voltages, gate bits and ticks do afterwards.
- R9: A `thr_time` of 0 or 1 raises the flag at the first tick inside a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Duration time base enable, one cycle wide |
| vdc | input | W | Signed DC-link voltage |
| vpole | input | NUM_LEGS*W | Signed measured pole voltages; leg k occupies bits [k*W +: W] |
| gate_top | input | NUM_LEGS | Top-switch command per leg, 1 = on |
| thr_volt | input | W | Unsigned voltage threshold |
| thr_time | input | CNT_W | Unsigned duration threshold in ticks |
| fault | output | NUM_LEGS | Latched fault flag per leg |

## Verification
A pulse counter that fails to clear, or that counts clock cycles instead of ticks, shows at the ports as a flag that rises early. With short pulses or a held error and no ticks, that happens within a few tick periods. A wrong estimate or an off-by-one threshold compare makes a healthy, exactly matching leg or an error sitting right at the threshold trip after `thr_time` ticks. A channel that stops its latch or shares state across legs shows up as a flag that drops or leaks to a neighbour on the next clock edge after the disturbing stimulus.

// File: rtl/pvfd_pkg.sv
package pvfd_pkg;

    // Per-leg supervision state
    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_COUNT = 2'd1,
        CH_TRIP  = 2'd2
    } ch_state_e;

    // Verdict of the duration stage for one leg
    typedef struct packed {
        logic active;   // voltage criterion currently met
        logic expire;   // duration criterion met on this edge
    } leg_verdict_t;

    // Next state of one channel from its current state and verdict
    function automatic ch_state_e next_state(input ch_state_e cur, input leg_verdict_t v);
        ch_state_e nxt;
        if (cur == CH_TRIP)      nxt = CH_TRIP;
        else if (v.expire)       nxt = CH_TRIP;
        else if (v.active)       nxt = CH_COUNT;
        else                     nxt = CH_IDLE;
        return nxt;
    endfunction

endpackage

// File: rtl/pole_err_calc.sv
module pole_err_calc #(
    parameter int W = 16
) (
    input  logic [W-1:0] vdc,
    input  logic [W-1:0] vmeas,
    input  logic         gate,
    input  logic [W-1:0] thr,
    output logic         over_thr
);
    localparam int EW = W + 2;

    logic signed [W-1:0]  half_link;
    logic signed [EW-1:0] half_ext;
    logic signed [EW-1:0] est_v;
    logic signed [EW-1:0] meas_ext;
    logic signed [EW-1:0] diff_v;
    logic        [EW-1:0] mag_v;
    logic        [EW-1:0] thr_ext;

    always_comb begin
        half_link = $signed(vdc) >>> 1;
        half_ext  = {{2{half_link[W-1]}}, half_link};
        est_v     = gate ? half_ext : -half_ext;
        meas_ext  = {{2{vmeas[W-1]}}, vmeas};
        diff_v    = meas_ext - est_v;
        mag_v     = diff_v[EW-1] ? $unsigned(-diff_v) : $unsigned(diff_v);
        thr_ext   = {2'b00, thr};
        over_thr  = (mag_v > thr_ext);
    end

endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             active,
    input  logic             hold,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (hold) begin
            cnt_q <= cnt_q;
        end else if (!active) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_inc[CNT_W-1:0];
        end
    end

    // Duration reached on the edge where the count would become >= limit
    assign expire = active && tick && !hold && (cnt_inc >= {1'b0, limit});

endmodule

// File: rtl/leg_channel.sv
module leg_channel
    import pvfd_pkg::*;
#(
    parameter int W     = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [W-1:0]     vdc,
    input  logic [W-1:0]     vmeas,
    input  logic             gate,
    input  logic [W-1:0]     thr_volt,
    input  logic [CNT_W-1:0] thr_time,
    output logic             over_thr,
    output logic             fault
);
    ch_state_e    state_q;
    leg_verdict_t verdict;
    logic         err_now;
    logic         expire_now;
    logic         tripped;

    assign tripped = (state_q == CH_TRIP);

    pole_err_calc #(.W(W)) u_err (
        .vdc      (vdc),
        .vmeas    (vmeas),
        .gate     (gate),
        .thr      (thr_volt),
        .over_thr (err_now)
    );

    pulse_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .active (err_now),
        .hold   (tripped),
        .limit  (thr_time),
        .expire (expire_now)
    );

    always_comb begin
        verdict.active = err_now;
        verdict.expire = expire_now;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= CH_IDLE;
        else     state_q <= next_state(state_q, verdict);
    end

    assign over_thr = err_now;
    assign fault    = tripped;

endmodule

// File: rtl/pole_fault_detector.sv
module pole_fault_detector #(
    parameter int W        = 16,
    parameter int CNT_W    = 8,
    parameter int NUM_LEGS = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic [W-1:0]          vdc,
    input  logic [NUM_LEGS*W-1:0] vpole,
    input  logic [NUM_LEGS-1:0]   gate_top,
    input  logic [W-1:0]          thr_volt,
    input  logic [CNT_W-1:0]      thr_time,
    output logic [NUM_LEGS-1:0]   fault
);
    logic [NUM_LEGS-1:0] over_thr;

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        leg_channel #(.W(W), .CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick),
            .vdc      (vdc),
            .vmeas    (vpole[g*W +: W]),
            .gate     (gate_top[g]),
            .thr_volt (thr_volt),
            .thr_time (thr_time),
            .over_thr (over_thr[g]),
            .fault    (fault[g])
        );
    end

endmodule

// File: rtl/pvfd_checker.sv
module pvfd_checker #(
    parameter int NUM_LEGS = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                tick,
    input logic [NUM_LEGS-1:0] over_thr,
    input logic [NUM_LEGS-1:0] fault
);
    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (fault == '0)); // R1

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_chk
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
            fault[g] |=> fault[g]); // R8
        AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
            $rose(fault[g]) |-> $past(tick)); // R4
        AST_RISE_NEEDS_ERR: assert property (@(posedge clk) disable iff (rst)
            $rose(fault[g]) |-> $past(over_thr[g])); // R3
    end
endmodule

bind pole_fault_detector pvfd_checker #(.NUM_LEGS(NUM_LEGS)) u_pvfd_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .over_thr (over_thr),
    .fault    (fault)
);

// File: tb/pole_fault_detector_bench.sv
module pole_fault_detector_bench;
    localparam int W = 16;
    localparam int CW = 8;
    localparam int NL = 3;
    localparam int TDIV = 20;   // 200 ns tick at 100 MHz

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            tick = 1'b0;
    logic [W-1:0]    vdc = 16'sd800;
    logic [NL*W-1:0] vpole = '0;
    logic [NL-1:0]   gate_top = '0;
    logic [W-1:0]    thr_volt = 16'd50;
    logic [CW-1:0]   thr_time = 8'd50;
    logic [NL-1:0]   fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pole_fault_detector #(.W(W), .CNT_W(CW), .NUM_LEGS(NL)) u_pole_fault_detector (
        .clk(clk), .rst(rst), .tick(tick), .vdc(vdc), .vpole(vpole),
        .gate_top(gate_top), .thr_volt(thr_volt), .thr_time(thr_time), .fault(fault)
    );

    task automatic chk(input string req, input logic [NL-1:0] act, input logic [NL-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: fault=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic t);
        tick = t;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            for (int j = 0; j < TDIV - 1; j++) step(1'b0);
            step(1'b1);
        end
    endtask

    // Expected pole voltage from requirement R2
    function automatic logic signed [W-1:0] est(input logic g);
        logic signed [W-1:0] h;
        h = $signed(vdc) >>> 1;
        return g ? h : -h;
    endfunction

    task automatic set_leg(input int k, input logic g, input int offs);
        gate_top[k] = g;
        vpole[k*W +: W] = est(g) + offs;
    endtask

    task automatic all_healthy();
        set_leg(0, 1'b1, 0);
        set_leg(1, 1'b0, 0);
        set_leg(2, 1'b1, 0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        all_healthy();
        step(1'b0);
        step(1'b0);
        chk("R1 during reset", fault, 3'b000);
        rst = 1'b0;
        step(1'b0);
        chk("R1 after reset", fault, 3'b000);
    endtask

    task automatic t_match();
        thr_volt = 16'd50; thr_time = 8'd50;
        do_reset();
        vdc = 16'sd801;
        all_healthy();
        run_ticks(30);
        gate_top = 3'b010;
        set_leg(0, 1'b0, 0); set_leg(1, 1'b1, 0); set_leg(2, 1'b0, 0);
        run_ticks(30);
        chk("R2 matching legs", fault, 3'b000);
        vdc = 16'sd800;
    endtask

    task automatic t_threshold();
        thr_volt = 16'd50; thr_time = 8'd50;
        do_reset();
        set_leg(0, 1'b1, 50);
        set_leg(1, 1'b0, -50);
        run_ticks(60);
        chk("R3 error equal to threshold", fault, 3'b000);
        set_leg(0, 1'b1, 51);
        set_leg(1, 1'b0, -51);
        run_ticks(50);
        chk("R3 error above threshold", fault, 3'b011);
    endtask

    task automatic t_no_tick();
        thr_volt = 16'd50; thr_time = 8'd50;
        do_reset();
        set_leg(2, 1'b1, -300);
        for (int i = 0; i < 600; i++) step(1'b0);
        chk("R4 no tick no fault", fault, 3'b000);
        run_ticks(50);
        chk("R4 ticks then fault", fault, 3'b100);
    endtask

    task automatic t_timing();
        thr_volt = 16'd50; thr_time = 8'd50;
        do_reset();
        set_leg(1, 1'b0, 800);   // measured +400 while expecting -400
        run_ticks(49);
        chk("R5 one tick before limit", fault, 3'b000);
        for (int j = 0; j < TDIV - 1; j++) step(1'b0);
        chk("R5 just before final tick", fault, 3'b000);
        step(1'b1);
        chk("R5 at final tick", fault, 3'b010);
    endtask

    task automatic t_short();
        thr_volt = 16'd50; thr_time = 8'd50;
        do_reset();
        for (int p = 0; p < 4; p++) begin
            set_leg(0, 1'b1, -800);
            run_ticks(49);
            set_leg(0, 1'b1, 0);
            step(1'b0);
        end
        chk("R6 short pulses discarded", fault, 3'b000);
        set_leg(0, 1'b1, -800);
        run_ticks(50);
        chk("R6 full pulse after gaps", fault, 3'b001);
    endtask

    task automatic t_indep_latch();
        thr_volt = 16'd50; thr_time = 8'd50;
        do_reset();
        set_leg(1, 1'b1, 200);
        set_leg(0, 1'b1, 50);
        set_leg(2, 1'b0, 20);
        run_ticks(55);
        chk("R7 only faulty leg flagged", fault, 3'b010);
        all_healthy();
        gate_top[1] = 1'b0;
        run_ticks(5);
        chk("R8 flag held after error removed", fault, 3'b010);
        set_leg(0, 1'b1, 400);
        run_ticks(50);
        chk("R8 R7 second leg joins", fault, 3'b011);
        rst = 1'b1;
        step(1'b0);
        rst = 1'b0;
        all_healthy();
        step(1'b0);
        chk("R1 reset clears latched flags", fault, 3'b000);
    endtask

    task automatic t_small_limit();
        thr_volt = 16'd50;
        thr_time = 8'd0;
        do_reset();
        set_leg(2, 1'b0, 500);
        for (int j = 0; j < TDIV - 1; j++) step(1'b0);
        chk("R9 limit 0 before tick", fault, 3'b000);
        step(1'b1);
        chk("R9 limit 0 first tick", fault, 3'b100);
        thr_time = 8'd1;
        do_reset();
        set_leg(0, 1'b1, 500);
        for (int j = 0; j < TDIV - 1; j++) step(1'b0);
        chk("R9 limit 1 before tick", fault, 3'b000);
        step(1'b1);
        chk("R9 limit 1 first tick", fault, 3'b001);
    endtask

    initial begin
        all_healthy();
        t_match();
        t_threshold();
        t_no_tick();
        t_timing();
        t_short();
        t_indep_latch();
        t_small_limit();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #1500000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule